// File: doc/BRIEF.md
# Saturating Execute ALU with Per-Class Flag Update

This block is the execute-stage arithmetic unit of a small 16-bit core. Each cycle it may take one operation with an opcode, two register operands, an 8-bit immediate, a 4-bit shift count, a destination register index and the current condition flags (zero, negative, overflow). It computes the write-back value, decides whether the register file is written, and produces the next flag values. All results are registered, so they appear one cycle after the operation is issued.

Signed addition and subtraction clamp to the most positive or most negative 16-bit value instead of wrapping, and they raise the overflow flag when they do. Bitwise AND and the two shifts only refresh the zero flag. The two byte-load operations leave every flag alone. A conditional add executes only while the incoming zero flag is set. Writes aimed at register 0 are dropped, so that register always reads as zero.

Top module: `salu_core`

## Requirements
- R1: Opcode encoding on `op_code` is 0 ADD, 1 SUB, 2 ADDZ, 3 AND, 4 SLL, 5 SRL, 6 LLB, 7 LHB. Results, `wr_en`, `wr_dst` and flags are registered: they reflect an issued operation on the clock edge that samples it, and `res_valid` is high for exactly that one cycle. With no issue, `res_valid` and `wr_en` are 0.
- R2: ADD computes `src_a + src_b` and SUB computes `src_a - src_b` as 16-bit two's complement; without overflow the exact result is written, with Z = (result == 0), N = result bit 15, V = 0.
- R3: When the true sum or difference exceeds 32767, the result is 32767 (0x7FFF) and V = 1, N = 0, Z = 0.
- R4: When the true sum or difference is below -32768, the result is -32768 (0x8000) and V = 1, N = 1, Z = 0.
- R5: AND, SLL and SRL set Z = (result == 0) and pass the incoming N and V through unchanged.
- R6: SLL shifts `src_a` left by the unsigned `shamt` keeping only 16 bits (so the sign can change); SRL shifts right filling with zeros; AND is bitwise `src_a & src_b`.
- R7: LLB writes `{8'h00, imm}` and leaves Z, N, V equal to the incoming flags.
- R8: LHB writes `{imm, src_a[7:0]}` (src_a carries the destination's current value) and leaves Z, N, V equal to the incoming flags.
- R9: ADDZ with incoming Z = 1 behaves as ADD (saturation and all three flags); with incoming Z = 0 it does not write (`wr_en` = 0) and the outgoing flags equal the incoming ones.
- R10: Any operation with `rd` = 0 gives `wr_en` = 0, while its flag update still takes effect.
- R11: While `rst` is high, `res_valid`, `wr_en`, `wr_dst`, `wr_data` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation select (encoding in R1) |
| rd | input | 4 | Destination register index |
| src_a | input | 16 | First operand; current destination value for LHB |
| src_b | input | 16 | Second operand |
| imm | input | 8 | Byte immediate for LLB/LHB |
| shamt | input | 4 | Unsigned shift count |
| z_in | input | 1 | Current zero flag |
| n_in | input | 1 | Current negative flag |
| v_in | input | 1 | Current overflow flag |
| res_valid | output | 1 | Registered outputs belong to an issued operation |
| wr_en | output | 1 | Register file write enable |
| wr_dst | output | 4 | Register file write index |
| wr_data | output | 16 | Write-back value |
| z_out | output | 1 | Next zero flag |
| n_out | output | 1 | Next negative flag |
| v_out | output | 1 | Next overflow flag |

## Verification
The write suppression for register 0 and the flag update of the same operation land in one cycle, and so do the ADDZ predicate and the register-0 suppression. The bench issues a saturating ADD and a zero-result SUB into register 0 and expects `wr_en` low while Z, N and V still show the new values, then issues ADDZ to register 0 with Z set and with Z clear, expecting no write in both cases and fresh flags only in the first.

// File: rtl/salu_pkg.sv
package salu_pkg;

    localparam int DATA_W  = 16;
    localparam int IMM_W   = 8;
    localparam int SHAMT_W = 4;
    localparam int REG_W   = 4;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_ADDZ = 3'd2,
        OP_AND  = 3'd3,
        OP_SLL  = 3'd4,
        OP_SRL  = 3'd5,
        OP_LLB  = 3'd6,
        OP_LHB  = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic v;
    } flags_t;

    typedef enum logic [1:0] {
        CLS_ARITH = 2'd0,
        CLS_LOGIC = 2'd1,
        CLS_BYTE  = 2'd2
    } op_class_e;

    function automatic op_class_e class_of(input alu_op_e op);
        case (op)
            OP_ADD, OP_SUB, OP_ADDZ: class_of = CLS_ARITH;
            OP_AND, OP_SLL, OP_SRL:  class_of = CLS_LOGIC;
            default:                 class_of = CLS_BYTE;
        endcase
    endfunction

endpackage

// File: rtl/salu_addsub.sv
module salu_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         subtract,
    output logic [W-1:0] result,
    output logic         clamped
);
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff   = subtract ? ~opb : opb;
        wide    = {opa[W-1], opa} + {b_eff[W-1], b_eff} + {{W{1'b0}}, subtract};
        clamped = wide[W] ^ wide[W-1];
        if (!clamped)
            result = wide[W-1:0];
        else if (wide[W])
            result = MAX_NEG;
        else
            result = MAX_POS;
    end
endmodule

// File: rtl/salu_logic.sv
module salu_logic
    import salu_pkg::*;
#(
    parameter int W  = 16,
    parameter int SW = 4
) (
    input  alu_op_e       op,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    input  logic [SW-1:0] amount,
    output logic [W-1:0]  result
);
    always_comb begin
        case (op)
            OP_SLL:  result = opa << amount;
            OP_SRL:  result = opa >> amount;
            default: result = opa & opb;
        endcase
    end
endmodule

// File: rtl/salu_byteload.sv
module salu_byteload #(
    parameter int W  = 16,
    parameter int IW = 8
) (
    input  logic          upper,
    input  logic [W-1:0]  current,
    input  logic [IW-1:0] byte_val,
    output logic [W-1:0]  result
);
    localparam int HI_W = W - IW;

    always_comb begin
        if (upper)
            result = {byte_val[HI_W-1:0], current[IW-1:0]};
        else
            result = {{HI_W{1'b0}}, byte_val};
    end
endmodule

// File: rtl/salu_core.sv
module salu_core
    import salu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                issue,
    input  logic [2:0]          op_code,
    input  logic [REG_W-1:0]    rd,
    input  logic [DATA_W-1:0]   src_a,
    input  logic [DATA_W-1:0]   src_b,
    input  logic [IMM_W-1:0]    imm,
    input  logic [SHAMT_W-1:0]  shamt,
    input  logic                z_in,
    input  logic                n_in,
    input  logic                v_in,
    output logic                res_valid,
    output logic                wr_en,
    output logic [REG_W-1:0]    wr_dst,
    output logic [DATA_W-1:0]   wr_data,
    output logic                z_out,
    output logic                n_out,
    output logic                v_out
);
    alu_op_e       op;
    op_class_e     cls;
    flags_t        cur_flags, nxt_flags, flags_q;
    logic [DATA_W-1:0] arith_res, logic_res, byte_res, sel_res;
    logic          arith_ovf;
    logic          commit;

    assign op        = alu_op_e'(op_code);
    assign cls       = class_of(op);
    assign cur_flags = '{z: z_in, n: n_in, v: v_in};

    salu_addsub #(.W(DATA_W)) u_arith (
        .opa      (src_a),
        .opb      (src_b),
        .subtract (op == OP_SUB),
        .result   (arith_res),
        .clamped  (arith_ovf)
    );

    salu_logic #(.W(DATA_W), .SW(SHAMT_W)) u_logic (
        .op     (op),
        .opa    (src_a),
        .opb    (src_b),
        .amount (shamt),
        .result (logic_res)
    );

    salu_byteload #(.W(DATA_W), .IW(IMM_W)) u_byte (
        .upper    (op == OP_LHB),
        .current  (src_a),
        .byte_val (imm),
        .result   (byte_res)
    );

    always_comb begin
        sel_res   = byte_res;
        nxt_flags = cur_flags;
        commit    = 1'b1;
        case (cls)
            CLS_ARITH: begin
                sel_res = arith_res;
                if (op == OP_ADDZ && !z_in) begin
                    commit = 1'b0;
                end else begin
                    nxt_flags.z = (arith_res == '0);
                    nxt_flags.n = arith_res[DATA_W-1];
                    nxt_flags.v = arith_ovf;
                end
            end
            CLS_LOGIC: begin
                sel_res     = logic_res;
                nxt_flags.z = (logic_res == '0);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            wr_en     <= 1'b0;
            wr_dst    <= '0;
            wr_data   <= '0;
            flags_q   <= '0;
        end else begin
            res_valid <= issue;
            wr_en     <= issue && commit && (rd != '0);
            if (issue) begin
                wr_dst  <= rd;
                wr_data <= sel_res;
                flags_q <= nxt_flags;
            end
        end
    end

    assign z_out = flags_q.z;
    assign n_out = flags_q.n;
    assign v_out = flags_q.v;

    // R10
    r0_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_dst != '0));

    // R1
    idle_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        !issue |=> (!res_valid && !wr_en));

    // R5
    logic_nv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && cls == CLS_LOGIC) |=> (n_out == $past(n_in) && v_out == $past(v_in)));

    // R3
    sat_value_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && cls == CLS_ARITH && !(op == OP_ADDZ && !z_in))
        |=> (!v_out || wr_data == 16'h7FFF || wr_data == 16'h8000));

    // R9
    addz_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && op == OP_ADDZ && !z_in)
        |=> (!wr_en && z_out == 1'b0 && n_out == $past(n_in) && v_out == $past(v_in)));

    // R7
    byte_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && cls == CLS_BYTE)
        |=> (z_out == $past(z_in) && n_out == $past(n_in) && v_out == $past(v_in)));

    // R2
    arith_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && (op == OP_ADD || op == OP_SUB)) |=> (z_out == (wr_data == '0)));

endmodule

// File: tb/sim_salu_core.sv
module sim_salu_core;
    localparam int CLK_P = 10;

    logic        clk, rst, issue;
    logic [2:0]  op_code;
    logic [3:0]  rd;
    logic [15:0] src_a, src_b;
    logic [7:0]  imm;
    logic [3:0]  shamt;
    logic        z_in, n_in, v_in;
    logic        res_valid, wr_en;
    logic [3:0]  wr_dst;
    logic [15:0] wr_data;
    logic        z_out, n_out, v_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    salu_core u0 (
        .clk(clk), .rst(rst), .issue(issue), .op_code(op_code), .rd(rd),
        .src_a(src_a), .src_b(src_b), .imm(imm), .shamt(shamt),
        .z_in(z_in), .n_in(n_in), .v_in(v_in),
        .res_valid(res_valid), .wr_en(wr_en), .wr_dst(wr_dst), .wr_data(wr_data),
        .z_out(z_out), .n_out(n_out), .v_out(v_out)
    );

    initial clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one operation, then sample its registered outputs one cycle later.
    task automatic run_op(input string req, input logic [2:0] op, input logic [3:0] dst,
                          input logic [15:0] a, input logic [15:0] b, input logic [7:0] im,
                          input logic [3:0] sh, input logic [2:0] fin,
                          input bit exp_we, input bit cmp_data, input logic [15:0] exp_d,
                          input logic [2:0] exp_f);
        logic [19:0] act, exp;
        @(negedge clk);
        issue = 1'b1; op_code = op; rd = dst; src_a = a; src_b = b; imm = im; shamt = sh;
        {z_in, n_in, v_in} = fin;
        @(negedge clk);
        issue = 1'b0;
        act = {wr_en, cmp_data ? wr_data : 16'h0, z_out, n_out, v_out};
        exp = {exp_we, cmp_data ? exp_d : 16'h0, exp_f};
        check(res_valid && act == exp, req, {12'h0, act}, {12'h0, exp});
    endtask

    task automatic t_reset();
        rst = 1'b1; issue = 1'b0; op_code = 3'd0; rd = 4'd0; src_a = '0; src_b = '0;
        imm = '0; shamt = '0; z_in = 0; n_in = 0; v_in = 0;
        repeat (3) @(negedge clk);
        // R11
        check({res_valid, wr_en, wr_dst, wr_data, z_out, n_out, v_out} == '0, "R11",
              {7'h0, res_valid, wr_en, wr_dst, wr_data, z_out, n_out, v_out}, 32'h0);
        rst = 1'b0;
    endtask

    task automatic t_add_sub();
        run_op("R2 add", 3'd0, 4'd6, 16'd45, 16'd45, 8'd0, 4'd0, 3'b000, 1, 1, 16'd90, 3'b000);
        run_op("R2 sub zero", 3'd1, 4'd10, 16'd0, 16'd0, 8'd0, 4'd0, 3'b011, 1, 1, 16'd0, 3'b100);
        run_op("R2 sub neg", 3'd1, 4'd2, 16'd5, 16'd9, 8'd0, 4'd0, 3'b000, 1, 1, 16'hFFFC, 3'b010);
    endtask

    task automatic t_saturate();
        run_op("R3 add pos", 3'd0, 4'd12, 16'd19200, 16'd29184, 8'd0, 4'd0, 3'b110, 1, 1, 16'h7FFF, 3'b001);
        run_op("R3 sub pos", 3'd1, 4'd3, 16'h7FFF, 16'hFFFF, 8'd0, 4'd0, 3'b000, 1, 1, 16'h7FFF, 3'b001);
        run_op("R4 sub neg", 3'd1, 4'd4, 16'h8000, 16'd1, 8'd0, 4'd0, 3'b000, 1, 1, 16'h8000, 3'b011);
        run_op("R4 add neg", 3'd0, 4'd5, 16'h8001, 16'h8001, 8'd0, 4'd0, 3'b000, 1, 1, 16'h8000, 3'b011);
    endtask

    task automatic t_logic_shift();
        run_op("R5 and", 3'd3, 4'd1, 16'd11264, 16'd11264, 8'd0, 4'd0, 3'b111, 1, 1, 16'd11264, 3'b011);
        run_op("R5 and zero", 3'd3, 4'd1, 16'h00F0, 16'h0F00, 8'd0, 4'd0, 3'b001, 1, 1, 16'h0000, 3'b101);
        run_op("R6 sll", 3'd4, 4'd13, 16'd29388, 16'd0, 8'd0, 4'd1, 3'b101, 1, 1, 16'hE598, 3'b001);
        run_op("R6 srl", 3'd5, 4'd14, 16'd29388, 16'd0, 8'd0, 4'd2, 3'b010, 1, 1, 16'd7347, 3'b010);
        run_op("R6 srl zero fill", 3'd5, 4'd7, 16'h8000, 16'd0, 8'd0, 4'd15, 3'b000, 1, 1, 16'h0001, 3'b000);
    endtask

    task automatic t_byte_loads();
        run_op("R7 llb", 3'd6, 4'd11, 16'd17920, 16'd0, 8'd164, 4'd0, 3'b110, 1, 1, 16'd164, 3'b110);
        run_op("R8 lhb", 3'd7, 4'd14, 16'h1CB3, 16'd0, 8'd114, 4'd0, 3'b001, 1, 1, 16'd29363, 3'b001);
    endtask

    task automatic t_addz();
        run_op("R9 addz taken", 3'd2, 4'd9, 16'd3, 16'd4, 8'd0, 4'd0, 3'b111, 1, 1, 16'd7, 3'b000);
        run_op("R9 addz skipped", 3'd2, 4'd9, 16'd3, 16'd4, 8'd0, 4'd0, 3'b011, 0, 0, 16'd0, 3'b011);
        run_op("R9 addz sat", 3'd2, 4'd8, 16'h7000, 16'h7000, 8'd0, 4'd0, 3'b100, 1, 1, 16'h7FFF, 3'b001);
    endtask

    task automatic t_r0_overlap();
        run_op("R10 add r0 sat", 3'd0, 4'd0, 16'h7FFF, 16'd1, 8'd0, 4'd0, 3'b000, 0, 0, 16'd0, 3'b001);
        run_op("R10 sub r0 zero", 3'd1, 4'd0, 16'd7, 16'd7, 8'd0, 4'd0, 3'b011, 0, 0, 16'd0, 3'b100);
        run_op("R10 addz r0 z=1", 3'd2, 4'd0, 16'hFFFF, 16'hFFFF, 8'd0, 4'd0, 3'b101, 0, 0, 16'd0, 3'b010);
        run_op("R10 addz r0 z=0", 3'd2, 4'd0, 16'd1, 16'd1, 8'd0, 4'd0, 3'b011, 0, 0, 16'd0, 3'b011);
    endtask

    task automatic t_idle();
        @(negedge clk);
        issue = 1'b0;
        @(negedge clk);
        // R1
        check(!res_valid && !wr_en, "R1 idle", {30'h0, res_valid, wr_en}, 32'h0);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_add_sub();
        t_saturate();
        t_logic_shift();
        t_byte_loads();
        t_addz();
        t_r0_overlap();
        t_idle();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule